// File: doc/BRIEF.md
# Per-Processor Timer Mode Select Register

This block is a configuration register in the system timer's register window. It decides, for each processor-local timer, whether that timer acts as a free-running user counter or as a normal periodic timer. Software writes a bit mask: a set bit i puts processor timer i into user-counter mode, and a clear bit returns it to timer mode. A read returns the mask that is stored.

Each write also restarts every processor timer. In the cycle after the write, every timer gets a one-cycle restart strobe, whether or not its own mode bit changed. Each timer whose bit was set also gets a one-cycle interrupt-clear pulse and a one-cycle pulse telling it to load an all-ones limit. These pulses arrive together with the new mode vector. The counting logic of the processor timers is not part of this block.

Top module: `tmr_mode_cfg`

## Requirements
- R1: After reset the stored mask is zero. All mode outputs are 0 (timer mode) and no strobe is active.
- R2: A write with address index 4 (byte offset 0x10 in the window, word index = byte address bits [4:2]) stores the write data masked to the low NUM_TMR bits. The new mask appears on mode_o one cycle after the write.
- R3: Bit i of the stored mask set means processor timer i is in user-counter mode. Bit i clear means normal timer mode.
- R4: Every write to index 4 produces, in the next cycle, a one-cycle restart pulse on all NUM_TMR restart_o bits, even if the mask is unchanged.
- R5: In that same cycle, irq_clr_o and lim_max_o pulse only for the timers whose bit in the written value is set. For the timers whose bit is clear they stay low.
- R6: A read at index 4 returns the stored mask, zero-extended, on rdata_o in the same cycle (rdata_o is combinational). A read at any other index returns 0.
- R7: Writes to any other index leave the mask unchanged and produce no pulse.
- R8: Single-bit values (1, 2, 4, 8) select one timer. 0xF selects timers 0 to 3 together. Upper data bits beyond NUM_TMR are ignored.
- R9: All pulses last exactly one cycle. Back-to-back writes give pulses in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write enable |
| rd_en_i | input | 1 | Register read enable |
| addr_i | input | 5 | Byte address within the 0x20-byte window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data |
| mode_o | output | NUM_TMR | Per-timer user-counter mode |
| restart_o | output | NUM_TMR | Per-timer stop/reload/restart pulse |
| irq_clr_o | output | NUM_TMR | Per-timer interrupt-clear pulse |
| lim_max_o | output | NUM_TMR | Per-timer load-all-ones-limit pulse |

## Verification
The bench targets these corner cases:
- Rewriting an unchanged mask. A design that only restarts the timers whose bits change would miss the restart pulses here.
- Clearing a bit that was set. A design that keeps the interrupt clear tied to the old mask rather than the written value would pulse the wrong timers.
- Data with upper bits set above NUM_TMR. A design that does not mask them would leak them into mode_o or rdata_o.
- Writes to neighbouring indices and back-to-back writes. These catch address decoding that is too loose and pulses that stretch over more than one cycle.

// File: rtl/tmr_mode_cfg_pkg.sv
package tmr_mode_cfg_pkg;
  localparam int unsigned ADDR_W   = 5;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned IDX_W    = ADDR_W - 2;
  localparam logic [IDX_W-1:0] CFG_IDX = 3'd4;

  typedef struct packed {
    logic             wr;
    logic             rd;
    logic [IDX_W-1:0] idx;
  } reg_acc_t;
endpackage

// File: rtl/tmr_mode_dec.sv
module tmr_mode_dec
  import tmr_mode_cfg_pkg::*;
(
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              cfg_wr_o,
  output logic              cfg_rd_o
);
  reg_acc_t acc;
  always_comb begin
    acc.wr  = wr_en_i;
    acc.rd  = rd_en_i;
    acc.idx = addr_i[ADDR_W-1:2];
  end
  assign cfg_wr_o = acc.wr && (acc.idx == CFG_IDX);
  assign cfg_rd_o = acc.rd && (acc.idx == CFG_IDX);
endmodule

// File: rtl/tmr_mode_slice.sv
module tmr_mode_slice (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic bit_i,
  output logic mode_o,
  output logic restart_o,
  output logic irq_clr_o,
  output logic lim_max_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o    <= 1'b0;
      restart_o <= 1'b0;
      irq_clr_o <= 1'b0;
      lim_max_o <= 1'b0;
    end else begin
      restart_o <= wr_i;
      irq_clr_o <= wr_i & bit_i;
      lim_max_o <= wr_i & bit_i;
      if (wr_i) mode_o <= bit_i;
    end
  end
endmodule

// File: rtl/tmr_mode_cfg.sv
module tmr_mode_cfg
  import tmr_mode_cfg_pkg::*;
#(
  parameter int unsigned NUM_TMR = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [4:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [NUM_TMR-1:0] mode_o,
  output logic [NUM_TMR-1:0] restart_o,
  output logic [NUM_TMR-1:0] irq_clr_o,
  output logic [NUM_TMR-1:0] lim_max_o
);
  localparam int unsigned PAD_W = DATA_W - NUM_TMR;

  logic cfg_wr, cfg_rd;

  tmr_mode_dec u_dec (
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .cfg_wr_o(cfg_wr),
    .cfg_rd_o(cfg_rd)
  );

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_slice
    tmr_mode_slice u_slice (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (cfg_wr),
      .bit_i    (wdata_i[i]),
      .mode_o   (mode_o[i]),
      .restart_o(restart_o[i]),
      .irq_clr_o(irq_clr_o[i]),
      .lim_max_o(lim_max_o[i])
    );
  end

  if (PAD_W > 0) begin : g_pad
    assign rdata_o = cfg_rd ? {{PAD_W{1'b0}}, mode_o} : '0;
  end else begin : g_nopad
    assign rdata_o = cfg_rd ? mode_o[DATA_W-1:0] : '0;
  end
endmodule

// File: rtl/tmr_mode_cfg_chk.sv
module tmr_mode_cfg_chk #(
  parameter int unsigned NUM_TMR = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [4:0]         addr_i,
  input logic [31:0]        wdata_i,
  input logic [NUM_TMR-1:0] mode_o,
  input logic [NUM_TMR-1:0] restart_o,
  input logic [NUM_TMR-1:0] irq_clr_o,
  input logic [NUM_TMR-1:0] lim_max_o
);
  logic hit;
  assign hit = wr_en_i && (addr_i[4:2] == 3'd4);

  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (mode_o == '0) && (restart_o == '0));

  assert_mode_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> mode_o == $past(wdata_i[NUM_TMR-1:0]));

  assert_restart_all_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> (&restart_o));

  assert_clr_sel_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> (irq_clr_o == $past(wdata_i[NUM_TMR-1:0])) && (lim_max_o == irq_clr_o));

  assert_other_idx_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> $stable(mode_o) && (restart_o == '0) && (irq_clr_o == '0));

  assert_pulse_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clr_o & ~mode_o) == '0);
endmodule

bind tmr_mode_cfg tmr_mode_cfg_chk #(.NUM_TMR(NUM_TMR)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .mode_o   (mode_o),
  .restart_o(restart_o),
  .irq_clr_o(irq_clr_o),
  .lim_max_o(lim_max_o)
);

// File: tb/tmr_mode_cfg_tb_top.sv
module tmr_mode_cfg_tb_top;
  localparam int N = 16;
  logic clk = 0, rst_ni = 0;
  logic wr_en = 0, rd_en = 0;
  logic [4:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [N-1:0] mode, restart, irq_clr, lim_max;
  int tests = 0, fails = 0;

  // reference model state
  logic [N-1:0] m_mask = '0, m_rst = '0, m_clr = '0;

  always #5 clk = ~clk;

  tmr_mode_cfg #(.NUM_TMR(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .mode_o(mode),
    .restart_o(restart), .irq_clr_o(irq_clr), .lim_max_o(lim_max));

  always @(posedge clk) begin
    if (rst_ni) begin
      if (wr_en && addr[4:2] == 3'd4) begin
        m_mask <= wdata[N-1:0];
        m_rst  <= '1;
        m_clr  <= wdata[N-1:0];
      end else begin
        m_rst <= '0;
        m_clr <= '0;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // continuous comparison every cycle on negedge (R3 R4 R5 R9)
  always @(negedge clk) if (rst_ni) begin
    chk("R3 mode", 32'(mode), 32'(m_mask));
    chk("R4 restart", 32'(restart), 32'(m_rst));
    chk("R5 irq_clr", 32'(irq_clr), 32'(m_clr));
    chk("R5 lim_max", 32'(lim_max), 32'(m_clr));
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); rd_en = 1; addr = a; #1;
    chk(req, rdata, exp);
    rd_en = 0;
  endtask

  initial begin
    #200000;
    fails++; tests++;
    $display("FAIL watchdog act=hang exp=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 mode", 32'(mode), 0);
    chk("R1 restart", 32'(restart), 0);
    rst_ni = 1;
    rd(5'h10, 0, "R1 read");
    wr(5'h10, 32'h1); rd(5'h10, 32'h1, "R2 R8 single");
    wr(5'h10, 32'h8); rd(5'h10, 32'h8, "R8 bit3");
    wr(5'h10, 32'hF); rd(5'h10, 32'hF, "R8 all four");
    wr(5'h10, 32'hF);                      // unchanged mask, R4 restart still
    wr(5'h10, 32'h2);                      // clear bits, R5 selectivity
    wr(5'h10, 32'hABCD_1234); rd(5'h10, 32'h1234, "R2 R8 masked");
    wr(5'h0C, 32'hFFFF);  rd(5'h10, 32'h1234, "R7 idx3");
    wr(5'h14, 32'h0);     rd(5'h10, 32'h1234, "R7 idx5");
    wr(5'h00, 32'h5);     rd(5'h10, 32'h1234, "R7 idx0");
    rd(5'h14, 0, "R6 other idx");
    // back-to-back writes R9
    @(negedge clk); wr_en = 1; addr = 5'h10; wdata = 32'h3;
    @(negedge clk); wdata = 32'h4;
    @(negedge clk); wr_en = 0;
    rd(5'h10, 32'h4, "R9 b2b");
    wr(5'h10, 32'h0); rd(5'h10, 0, "R3 clear all");
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule